// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port

This block is a small memory-mapped I/O port for six external pins. It holds an output latch and a direction latch for each pin, drives registered pad controls (drive value, output enable, weak pull-up enable) and returns synchronized pin levels on a simple one-cycle read bus. Software selects a register with a one-bit address. Address 0 is the port data register. Address 1 is the direction register.

Several pins are shared with other functions, and the port handles each case itself. Pin 3 can only be an input. Pins 5 and 4 belong to the oscillator unless an RC oscillator mode is selected, and pin 4 can also carry a clock output. Any pin flagged in the analog-select mask is masked out of port reads. Pin 3 can also serve as the master-clear input. A single pull-up enable and a single change-interrupt enable cover pins 0, 1 and 3.

The change detector compares the live synchronized levels with a snapshot taken at the last data-register read. A mismatch raises a sticky flag that software clears by pulsing a clear input.

Top module: `gpio6_port`

## Requirements
- R1: After a synchronous reset every direction bit is 1, so a direction read returns 0xFF. All `pin_oe` bits are 0, `pin_out` is 0 and `ioc_flag` is 0.
- R2: A direction bit of 0 enables that pin's driver, so `pin_oe` goes to 1 and `pin_out` carries the data latch bit. A direction bit of 1 sets `pin_oe` to 0. Writes to address 0 load the data latch and writes to address 1 load the direction latch, each from `bus_wdata[5:0]`.
- R3: A read of address 0 returns the pin levels after a two-flop synchronizer, never the latch contents. Bits 7:6 read as 0. `bus_rdata` is valid in the cycle after `bus_rd` is sampled.
- R4: Pin 3 is input-only. Its `pin_oe` and `pin_out` stay 0, its direction bit always reads as 1, and writes to that bit are ignored.
- R5: A pin whose bit is set in `ana_sel` reads as 0 in a data read.
- R6: In the non-RC oscillator modes (`osc_mode` 00 crystal, 01 external clock), pins 5 and 4 read as 0 and their direction bits read as 1. Writes to those direction bits are ignored and their `pin_oe` is 0.
- R7: In the RC modes (`osc_mode` 10 internal RC, 11 external RC), direction bits 5 and 4 are writable. When `clkout_en` is 1 in an RC mode, pin 4 reads as 0, writes to direction bit 4 have no effect, and `pin_oe[4]` is 0.
- R8: `pull_en` drives `pin_pu` for pins 0, 1 and 3 together. `mclr_en` forces `pin_pu[3]` to 1. All other `pin_pu` bits are 0.
- R9: With `ioc_en` set, any eligible pin whose synchronized level differs from the snapshot taken at the last data read sets `ioc_flag`. Eligible pins are 0, 1 and 3, excluding any flagged in `ana_sel`. The flag stays set until `ioc_clr`, and a new set wins over a clear in the same cycle. With `ioc_en` clear the flag is never set.
- R10: When `mclr_en` is 1, pin 3 reads as 0 and is excluded from change detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 selects data register, 1 selects direction register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| osc_mode | input | 2 | 00 crystal, 01 external clock, 10 internal RC, 11 external RC |
| clkout_en | input | 1 | Pin 4 carries the clock output (RC modes) |
| mclr_en | input | 1 | Pin 3 acts as master clear |
| ana_sel | input | 6 | Pins assigned to analog inputs |
| pull_en | input | 1 | Shared weak pull-up enable for pins 0, 1, 3 |
| ioc_en | input | 1 | Shared change-interrupt enable |
| ioc_clr | input | 1 | Clears the change flag |
| pin_in | input | 6 | Pad input levels |
| pin_out | output | 6 | Pad drive values |
| pin_oe | output | 6 | Pad output enables |
| pin_pu | output | 6 | Pad weak pull-up enables |
| ioc_flag | output | 1 | Sticky change-interrupt flag |

## Verification
The bench drives a pin high from the latch while holding its input low. A port that returned the latch instead of the pad would read 1 there. It writes direction bits 5:4 in a crystal mode, then switches to an RC mode and reads them back, which exposes a design that stores the write while masking it. It writes direction bit 4 with the clock output enabled, where a wrong port would turn the driver on. For change detection it checks that the flag stays set after the pin returns to its old level, that pins 2 and 3 in master-clear mode never raise it, and that a change left pending while master clear was on shows up as soon as master clear is released.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  typedef enum logic [1:0] {
    OSC_XTAL   = 2'b00,
    OSC_EXTCLK = 2'b01,
    OSC_INTRC  = 2'b10,
    OSC_EXTRC  = 2'b11
  } osc_mode_e;

  localparam int DATA_W      = 8;
  localparam int NPINS       = 6;
  localparam logic REG_DATA  = 1'b0;
  localparam logic REG_DIR   = 1'b1;

  function automatic logic is_rc(input osc_mode_e m);
    return (m == OSC_INTRC) || (m == OSC_EXTRC);
  endfunction
endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio6_dir_reg.sv
module gpio6_dir_reg #(
  parameter int NP      = 6,
  parameter int IN_ONLY = 3,
  parameter int CLK_PIN = 4,
  parameter int OSC_LO  = 4,
  parameter int OSC_HI  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [NP-1:0] wdata,
  input  logic          osc_rc,
  input  logic          clkout_en,
  output logic [NP-1:0] dir_eff,
  output logic [NP-1:0] osc_claim
);
  logic [NP-1:0] dir_q;
  logic [NP-1:0] wr_mask;
  logic          clk_claim;

  assign clk_claim = osc_rc & clkout_en;

  always_comb begin
    wr_mask   = '1;
    osc_claim = '0;
    dir_eff   = dir_q;
    for (int i = 0; i < NP; i++) begin
      if (i >= OSC_LO && i <= OSC_HI && !osc_rc) begin
        wr_mask[i]   = 1'b0;
        osc_claim[i] = 1'b1;
        dir_eff[i]   = 1'b1;
      end
      if (i == CLK_PIN && clk_claim) begin
        wr_mask[i]   = 1'b0;
        osc_claim[i] = 1'b1;
      end
      if (i == IN_ONLY) begin
        wr_mask[i] = 1'b0;
        dir_eff[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        dir_q <= '1;
    else if (wr_en) dir_q <= (dir_q & ~wr_mask) | (wdata & wr_mask);
  end
endmodule

// File: rtl/gpio6_ioc.sv
module gpio6_ioc #(
  parameter int          NP        = 6,
  parameter logic [5:0]  ELIG_MASK = 6'b001011,
  parameter int          MCLR_PIN  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] lvl,
  input  logic          capture,
  input  logic [NP-1:0] ana_sel,
  input  logic          mclr_en,
  input  logic          ioc_en,
  input  logic          ioc_clr,
  output logic          flag
);
  logic [NP-1:0] snap_q;
  logic [NP-1:0] elig;
  logic          hit;

  always_comb begin
    elig = ELIG_MASK[NP-1:0] & ~ana_sel;
    if (mclr_en) elig[MCLR_PIN] = 1'b0;
  end

  assign hit = ioc_en && (((lvl ^ snap_q) & elig) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (capture) snap_q <= lvl;
      flag <= (flag & ~ioc_clr) | hit;
    end
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          NP          = 6,
  parameter int          SYNC_STAGES = 2,
  parameter int          IN_ONLY     = 3,
  parameter int          CLK_PIN     = 4,
  parameter int          OSC_LO      = 4,
  parameter int          OSC_HI      = 5,
  parameter logic [5:0]  SHARED_MASK = 6'b001011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    osc_mode,
  input  logic          clkout_en,
  input  logic          mclr_en,
  input  logic [NP-1:0] ana_sel,
  input  logic          pull_en,
  input  logic          ioc_en,
  input  logic          ioc_clr,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] pin_pu,
  output logic          ioc_flag
);
  localparam int          HI_W     = DW - NP;
  localparam logic [NP-1:0] LAT_MASK = ~(NP'(1) << IN_ONLY);

  logic          osc_rc;
  logic [NP-1:0] lvl;
  logic [NP-1:0] dir_eff;
  logic [NP-1:0] osc_claim;
  logic [NP-1:0] lat_q;
  logic [NP-1:0] rd_mask;
  logic [NP-1:0] pu_d;
  logic          unused_wdata_hi;

  assign osc_rc          = is_rc(osc_mode_e'(osc_mode));
  assign unused_wdata_hi = ^bus_wdata[DW-1:NP];

  gpio6_sync #(.W(NP), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl)
  );

  gpio6_dir_reg #(
    .NP(NP), .IN_ONLY(IN_ONLY), .CLK_PIN(CLK_PIN), .OSC_LO(OSC_LO), .OSC_HI(OSC_HI)
  ) u_dir (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && bus_addr == REG_DIR),
    .wdata     (bus_wdata[NP-1:0]),
    .osc_rc    (osc_rc),
    .clkout_en (clkout_en),
    .dir_eff   (dir_eff),
    .osc_claim (osc_claim)
  );

  gpio6_ioc #(.NP(NP), .ELIG_MASK(SHARED_MASK), .MCLR_PIN(IN_ONLY)) u_ioc (
    .clk     (clk),
    .rst     (rst),
    .lvl     (lvl),
    .capture (bus_rd && bus_addr == REG_DATA),
    .ana_sel (ana_sel),
    .mclr_en (mclr_en),
    .ioc_en  (ioc_en),
    .ioc_clr (ioc_clr),
    .flag    (ioc_flag)
  );

  // Output data latches; the input-only pin has none.
  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (bus_wr && bus_addr == REG_DATA) lat_q <= bus_wdata[NP-1:0] & LAT_MASK;
  end

  always_comb begin
    rd_mask = ana_sel | osc_claim;
    if (mclr_en) rd_mask[IN_ONLY] = 1'b1;
    pu_d = pull_en ? SHARED_MASK[NP-1:0] : '0;
    if (mclr_en) pu_d[IN_ONLY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_out   <= '0;
      pin_oe    <= '0;
      pin_pu    <= '0;
    end else begin
      if (bus_rd) begin
        if (bus_addr == REG_DATA) bus_rdata <= {{HI_W{1'b0}}, lvl & ~rd_mask};
        else                      bus_rdata <= {{HI_W{1'b1}}, dir_eff};
      end
      pin_out <= lat_q & LAT_MASK;
      pin_oe  <= ~dir_eff & ~osc_claim & LAT_MASK;
      pin_pu  <= pu_d;
    end
  end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [1:0] osc_mode,
  input logic       clkout_en,
  input logic       mclr_en,
  input logic [5:0] ana_sel,
  input logic       pull_en,
  input logic       ioc_en,
  input logic       ioc_clr,
  input logic [5:0] pin_in,
  input logic [5:0] pin_out,
  input logic [5:0] pin_oe,
  input logic [5:0] pin_pu,
  input logic       ioc_flag
);
  AST_PIN3_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !pin_oe[3] && !pin_out[3]); // R4
  AST_DIR3_READS_ONE: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr |=> bus_rdata[3]); // R4
  AST_DATA_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_addr |=> bus_rdata[7:6] == 2'b00); // R3
  AST_ANALOG_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_addr && ana_sel[0] |=> !bus_rdata[0]); // R5
  AST_OSC_PINS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !osc_mode[1] |=> pin_oe[5:4] == 2'b00); // R6
  AST_CLKOUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    osc_mode[1] && clkout_en |=> !pin_oe[4]); // R7
  AST_MCLR_PULLUP: assert property (@(posedge clk) disable iff (rst)
    mclr_en |=> pin_pu[3]); // R8
  AST_PU_UNSHARED_OFF: assert property (@(posedge clk) disable iff (rst)
    pin_pu[2] == 1'b0 && pin_pu[5:4] == 2'b00); // R8
  AST_IOC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ioc_clr && !ioc_en |=> !ioc_flag); // R9
  AST_IOC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(ioc_flag) |-> $past(ioc_en)); // R9
endmodule

bind gpio6_port gpio6_port_chk u_chk (.*);

// File: tb/gpio6_port_bench.sv
module gpio6_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] osc_mode = 2'b10;
  logic       clkout_en = 1'b0, mclr_en = 1'b0, pull_en = 1'b0;
  logic       ioc_en = 1'b0, ioc_clr = 1'b0;
  logic [5:0] ana_sel = 6'b010111;
  logic [5:0] pin_in = 6'b000000;
  logic [5:0] pin_out, pin_oe, pin_pu;
  logic       ioc_flag;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio6_port u_gpio6_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_mode(osc_mode),
    .clkout_en(clkout_en), .mclr_en(mclr_en), .ana_sel(ana_sel), .pull_en(pull_en),
    .ioc_en(ioc_en), .ioc_clr(ioc_clr), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu), .ioc_flag(ioc_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b1, v);
    check("R1 dir after reset", v, 8'hFF);
    check("R1 oe after reset", {2'b0, pin_oe}, 8'h00);
    check("R1 out after reset", {2'b0, pin_out}, 8'h00);
    check("R1 flag after reset", {7'b0, ioc_flag}, 8'h00);
  endtask

  task automatic t_drive;
    ana_sel = 6'b0; osc_mode = 2'b10;
    wr(1'b0, 8'h15); wr(1'b1, 8'h00); tick(2);
    check("R2 oe drive", {2'b0, pin_oe}, 8'h37);
    check("R2 out value", {2'b0, pin_out}, 8'h15);
    wr(1'b0, 8'h2A); tick(2);
    check("R2 R4 out no latch on pin3", {2'b0, pin_out}, 8'h22);
    wr(1'b1, 8'h3F); tick(2);
    check("R2 tri-state", {2'b0, pin_oe}, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    pin_in = 6'b101101; tick(3);
    rd(1'b0, v);
    check("R3 pin levels", v, 8'h2D);
    wr(1'b0, 8'hFF); wr(1'b1, 8'h00); pin_in = 6'b0; tick(3);
    rd(1'b0, v);
    check("R3 pad not latch", v, 8'h00);
    check("R3 latch still driven", {2'b0, pin_out}, 8'h37);
  endtask

  task automatic t_pin3;
    logic [7:0] v;
    rd(1'b1, v);
    check("R4 dir bit3 reads one", v, 8'hC8);
    check("R4 pin3 oe", {7'b0, pin_oe[3]}, 8'h00);
  endtask

  task automatic t_analog;
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    pin_in = 6'h3F; ana_sel = 6'b010111; tick(3);
    rd(1'b0, v);
    check("R5 analog pins read zero", v, 8'h28);
    ana_sel = 6'b0;
  endtask

  task automatic t_osc;
    logic [7:0] v;
    wr(1'b1, 8'h00);
    rd(1'b1, v);
    check("R7 rc dir writable", v, 8'hC8);
    osc_mode = 2'b00; tick(2);
    check("R6 osc pins no drive", {6'b0, pin_oe[5:4]}, 8'h00);
    rd(1'b1, v);
    check("R6 dir 5:4 read one", v, 8'hF8);
    rd(1'b0, v);
    check("R6 osc pins read zero", v, 8'h0F);
    wr(1'b1, 8'hFF);
    osc_mode = 2'b11;
    rd(1'b1, v);
    check("R6 dir 5:4 write ignored", v, 8'hCF);
    clkout_en = 1'b1;
    wr(1'b1, 8'hF0); tick(1);
    rd(1'b1, v);
    check("R7 dir4 locked by clkout", v, 8'hE8);
    check("R7 clkout pin no drive", {7'b0, pin_oe[4]}, 8'h00);
    rd(1'b0, v);
    check("R7 clkout pin reads zero", v, 8'h2F);
    clkout_en = 1'b0; osc_mode = 2'b10;
  endtask

  task automatic t_pullup;
    logic [7:0] v;
    pull_en = 1'b1; tick(2);
    check("R8 shared pull-up", {2'b0, pin_pu}, 8'h0B);
    pull_en = 1'b0; mclr_en = 1'b1; tick(2);
    check("R8 mclr pull-up", {2'b0, pin_pu}, 8'h08);
    rd(1'b0, v);
    check("R10 mclr pin reads zero", v, 8'h37);
    mclr_en = 1'b0; tick(2);
    check("R8 pull-ups off", {2'b0, pin_pu}, 8'h00);
  endtask

  task automatic t_ioc;
    logic [7:0] v;
    pin_in = 6'h3F; tick(3);
    rd(1'b0, v);
    ioc_en = 1'b1; tick(4);
    check("R9 no change no flag", {7'b0, ioc_flag}, 8'h00);
    pin_in[1] = 1'b0; tick(4);
    check("R9 change sets flag", {7'b0, ioc_flag}, 8'h01);
    pin_in[1] = 1'b1; tick(4);
    check("R9 flag sticky", {7'b0, ioc_flag}, 8'h01);
    ioc_clr = 1'b1; tick(1); ioc_clr = 1'b0; tick(1);
    check("R9 clear", {7'b0, ioc_flag}, 8'h00);
    pin_in[2] = 1'b0; tick(4);
    check("R9 pin2 not eligible", {7'b0, ioc_flag}, 8'h00);
    mclr_en = 1'b1; tick(1);
    pin_in[3] = 1'b0; tick(4);
    check("R10 mclr pin no change detect", {7'b0, ioc_flag}, 8'h00);
    mclr_en = 1'b0; tick(2);
    check("R10 pending change after mclr off", {7'b0, ioc_flag}, 8'h01);
    rd(1'b0, v);
    ioc_clr = 1'b1; tick(1); ioc_clr = 1'b0; tick(3);
    check("R9 read rebaselines", {7'b0, ioc_flag}, 8'h00);
    ioc_en = 1'b0;
    pin_in[0] = 1'b0; tick(4);
    check("R9 disabled no flag", {7'b0, ioc_flag}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_drive();
    t_readback();
    t_pin3();
    t_analog();
    t_osc();
    t_pullup();
    t_ioc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule